// File: doc/BRIEF.md
# Serial DAC Command Frame Writer

This block turns a 12-bit sample into a 32-bit command frame and shifts it to a serial digital-to-analog converter. It uses a write-only SPI link made of an active-low select, a serial clock and a data line. A one-cycle start strobe begins a transaction.

After reset the converter still has to be set up. The first start therefore sends a set-up frame that selects the internal reference. After a short pause with select high, it sends the write-and-update frame that carries the sample. A sticky flag records that set-up is done, so later starts send only the write frame.

When the write frame is complete the block raises a done flag. It holds that flag until the next baud-rate synchronization tick, so the upstream sequencer can step in lockstep with its serial port timing.

Top module: `dac_cmd_writer`

## Requirements
- R1: Every frame is 32 bits sent MSB first. Bits 31:28 are zero, bits 27:24 hold the command, bits 23:20 hold the channel address, bits 19:8 hold the sample and bits 7:0 hold the trailer.
- R2: The first start after reset sends the set-up frame 0x08000001 first. That frame has command 0x8, address 0, zero data and bit 0 set. The write frame follows it.
- R3: Once the set-up frame has been sent, later starts send only the write frame. A reset clears this memory, so the next start sends the set-up frame again.
- R4: A write frame has command 0x3 and address 0x0. Bits 19:8 hold the sample present on `sample_i` at the start strobe, and bits 7:0 are zero.
- R5: `cs_n_o` stays low for the whole of each frame, and each frame carries exactly 32 rising edges of `sclk_o`. When no frame is in progress, `cs_n_o` is high and `sclk_o` is low.
- R6: `done_o` rises when the write frame ends. It stays high until a cycle in which `sync_tick_i` is high, and it is low from the following cycle on.
- R7: `mosi_o` changes only while `sclk_o` is low, so it is stable for the whole high phase of the serial clock.
- R8: A start strobe is ignored while a transaction is in progress or while `done_o` is high. No extra frame is sent and the sample being sent is not altered.
- R9: Each phase of `sclk_o` lasts `HALF_DIV` system clocks. Between the set-up frame and the write frame, `cs_n_o` stays high for at least `2*HALF_DIV` system clocks, which is one serial clock period.
- R10: While reset is held and right after it is released, `cs_n_o` is 1, `sclk_o` is 0, `mosi_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a sample |
| sample_i | input | 12 | Sample captured at the start strobe |
| sync_tick_i | input | 1 | Baud-rate synchronization tick that releases done |
| done_o | output | 1 | Transaction complete, held until a sync tick |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data, MSB first |

## Verification
A wrong internal state shows up on the serial lines within one frame.

- A stale set-up flag shows as a missing or repeated 0x08000001 frame on the first start after reset.
- A wrong bit counter shows as a frame that does not carry exactly 32 clock edges while select is low.
- A sequencer that accepts a start it should ignore shows as an extra frame, or as a changed sample field, within the next 64 serial clock phases.
- Errors in the done handshake show as `done_o` dropping before a tick arrives, or staying high after one.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  localparam int FRAME_W  = 32;
  localparam int SAMPLE_W = 12;

  localparam logic [3:0] CMD_SETUP = 4'h8;
  localparam logic [3:0] CMD_WRUPD = 4'h3;
  localparam logic [3:0] ADDR_CH0  = 4'h0;

  // set-up frame: internal reference select, bit 0 set
  localparam logic [FRAME_W-1:0] SETUP_WORD =
    {4'h0, CMD_SETUP, ADDR_CH0, {SAMPLE_W{1'b0}}, 8'h01};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT_TX,
    ST_GAP,
    ST_WRITE_TX,
    ST_PAUSE
  } wr_state_t;

  function automatic logic [FRAME_W-1:0] write_word(input logic [SAMPLE_W-1:0] s);
    return {4'h0, CMD_WRUPD, ADDR_CH0, s, 8'h00};
  endfunction

endpackage

// File: rtl/dacw_halfdiv.sv
module dacw_halfdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               frame_end_o,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               mosi_o
);

  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  logic               busy_q, busy_d;
  logic               sclk_q, sclk_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BW-1:0]      cnt_q, cnt_d;

  always_comb begin
    busy_d      = busy_q;
    sclk_d      = sclk_q;
    sh_d        = sh_q;
    cnt_d       = cnt_q;
    frame_end_o = 1'b0;
    if (load_i) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      sh_d   = word_i;
      cnt_d  = '0;
    end else if (busy_q && tick_i) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        if (cnt_q == LAST_BIT) begin
          busy_d      = 1'b0;
          frame_end_o = 1'b1;
        end else begin
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cs_n_o = ~busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & sh_q[FRAME_W-1];

  AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);  // R5
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));  // R7
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);  // R8

endmodule

// File: rtl/dac_cmd_writer.sv
module dac_cmd_writer
  import dacw_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_SCLK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sync_tick_i,
  output logic                done_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                mosi_o
);

  localparam int GAP_TICKS = 2 * GAP_SCLK;
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

  wr_state_t           state_q, state_d;
  logic                done_q, done_d;
  logic                inited_q, inited_d;
  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic [GW-1:0]       gap_q, gap_d;
  logic                load;
  logic [FRAME_W-1:0]  word;
  logic                half_tick, frame_end, busy, div_en;

  assign div_en = (state_q == ST_INIT_TX) || (state_q == ST_GAP) ||
                  (state_q == ST_WRITE_TX);

  dacw_halfdiv #(.HALF_DIV(HALF_DIV)) i_div (
    .clk(clk), .rst_n(rst_n), .en_i(div_en), .tick_o(half_tick)
  );

  dacw_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(word),
    .tick_i(half_tick), .busy_o(busy), .frame_end_o(frame_end),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  always_comb begin
    state_d  = state_q;
    done_d   = done_q;
    inited_d = inited_q;
    sample_d = sample_q;
    gap_d    = gap_q;
    load     = 1'b0;
    word     = write_word(sample_q);
    case (state_q)
      ST_IDLE: if (start_i) begin
        sample_d = sample_i;
        load     = 1'b1;
        if (!inited_q) begin
          word    = SETUP_WORD;
          state_d = ST_INIT_TX;
        end else begin
          word    = write_word(sample_i);
          state_d = ST_WRITE_TX;
        end
      end
      ST_INIT_TX: if (frame_end) begin
        inited_d = 1'b1;
        gap_d    = '0;
        state_d  = ST_GAP;
      end
      ST_GAP: if (half_tick) begin
        if (gap_q == GAP_LAST) begin
          load    = 1'b1;
          state_d = ST_WRITE_TX;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_WRITE_TX: if (frame_end) begin
        done_d  = 1'b1;
        state_d = ST_PAUSE;
      end
      ST_PAUSE: if (sync_tick_i) begin
        done_d  = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      inited_q <= 1'b0;
      sample_q <= '0;
      gap_q    <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      inited_q <= inited_d;
      sample_q <= sample_d;
      gap_q    <= gap_d;
    end
  end

  assign done_o = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sync_tick_i) |=> done_o);  // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && sync_tick_i) |=> !done_o);  // R6
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    inited_q |=> inited_q);  // R3
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_PAUSE) |-> (cs_n_o && !sclk_o));  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);  // R8

endmodule

// File: tb/test_dac_cmd_writer.sv
`timescale 1ns/1ps
module test_dac_cmd_writer;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] sample_i;
  logic        sync_tick_i;
  logic        done_o, cs_n_o, sclk_o, mosi_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dac_cmd_writer #(.HALF_DIV(H), .GAP_SCLK(1)) i_dac_cmd_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
    .sync_tick_i(sync_tick_i), .done_o(done_o), .cs_n_o(cs_n_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  // serial receiver model
  logic [31:0] rx_sh;
  int          rx_bits = 0;
  logic [31:0] frames [8];
  int          fbits  [8];
  int          nframes = 0;

  always @(posedge sclk_o)
    if (cs_n_o === 1'b0) begin
      rx_sh = {rx_sh[30:0], mosi_o};
      rx_bits++;
    end

  always @(posedge cs_n_o)
    if (rx_bits > 0) begin
      if (nframes < 8) begin
        frames[nframes] = rx_sh;
        fbits[nframes]  = rx_bits;
      end
      nframes++;
      rx_bits = 0;
    end

  // line timing monitors sampled away from the active edge
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;
  int mosi_viol = 0, sclk_run = 0, sclk_bad = 0, cs_run = 0, last_gap = 0;

  always @(negedge clk) begin
    if (prev_sclk === 1'b1 && sclk_o === 1'b1 && mosi_o !== prev_mosi) mosi_viol++;
    if (sclk_o === 1'b1) sclk_run++;
    else if (prev_sclk === 1'b1) begin
      if (sclk_run != H) sclk_bad++;
      sclk_run = 0;
    end
    if (cs_n_o === 1'b1) cs_run++;
    else begin
      if (prev_cs === 1'b1) last_gap = cs_run;
      cs_run = 0;
    end
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
    prev_cs   = cs_n_o;
  end

  function automatic logic [31:0] exp_write(input logic [11:0] s);
    return {4'h0, 4'h3, 4'h0, s, 8'h00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nframes   = 0;
    rx_bits   = 0;
    mosi_viol = 0;
    sclk_bad  = 0;
    last_gap  = 0;
  endtask

  task automatic do_start(input logic [11:0] s);
    @(negedge clk);
    sample_i = s;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    sample_i = ~s;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_o !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    sync_tick_i = 1'b1;
    @(negedge clk);
    sync_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; sample_i = '0; sync_tick_i = 1'b0;
    repeat (4) @(negedge clk);
    check({cs_n_o, sclk_o, mosi_o, done_o} === 4'b1000, "R10 in reset",
          {28'h0, cs_n_o, sclk_o, mosi_o, done_o}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({cs_n_o, sclk_o, mosi_o, done_o} === 4'b1000, "R10 after release",
          {28'h0, cs_n_o, sclk_o, mosi_o, done_o}, 32'h8);
    clear_mon();
  endtask

  task automatic t_first_start();
    clear_mon();
    do_start(12'hA5C);
    wait_done();
    check(done_o === 1'b1, "R6 done raised", {31'h0, done_o}, 32'h1);
    check(nframes == 2, "R2 frame count", nframes, 2);
    check(frames[0] === 32'h08000001, "R2 setup frame", frames[0], 32'h08000001);
    check(frames[1] === exp_write(12'hA5C), "R1 R4 write frame", frames[1],
          exp_write(12'hA5C));
    check(fbits[0] == 32 && fbits[1] == 32, "R5 bits per frame", fbits[1], 32);
    check(last_gap >= 2 * H, "R9 select gap", last_gap, 2 * H);
    check(sclk_bad == 0, "R9 sclk phase", sclk_bad, 0);
    check(mosi_viol == 0, "R7 mosi stable", mosi_viol, 0);
    repeat (20) @(negedge clk);
    check(done_o === 1'b1, "R6 done held", {31'h0, done_o}, 32'h1);
    pulse_tick();
    check(done_o === 1'b0, "R6 done released", {31'h0, done_o}, 32'h0);
    check(cs_n_o === 1'b1 && sclk_o === 1'b0, "R5 idle lines",
          {30'h0, cs_n_o, sclk_o}, 32'h2);
  endtask

  task automatic t_second_start();
    clear_mon();
    do_start(12'h3F0);
    wait_done();
    pulse_tick();
    check(nframes == 1, "R3 no repeat setup", nframes, 1);
    check(frames[0] === exp_write(12'h3F0), "R4 latched sample", frames[0],
          exp_write(12'h3F0));
    check(fbits[0] == 32, "R5 bits per frame", fbits[0], 32);
    clear_mon();
    do_start(12'h000);
    wait_done();
    pulse_tick();
    check(frames[0] === exp_write(12'h000), "R1 zero sample", frames[0],
          exp_write(12'h000));
  endtask

  task automatic t_start_ignored();
    clear_mon();
    do_start(12'h123);
    repeat (20) @(negedge clk);
    do_start(12'hFFF);
    wait_done();
    do_start(12'hEEE);
    repeat (10) @(negedge clk);
    check(done_o === 1'b1, "R8 start in pause", {31'h0, done_o}, 32'h1);
    pulse_tick();
    repeat (300) @(negedge clk);
    check(nframes == 1, "R8 no extra frame", nframes, 1);
    check(frames[0] === exp_write(12'h123), "R8 sample kept", frames[0],
          exp_write(12'h123));
    check(cs_n_o === 1'b1 && done_o === 1'b0, "R8 idle after ignore",
          {30'h0, cs_n_o, done_o}, 32'h2);
  endtask

  task automatic t_reset_reinit();
    t_reset();
    do_start(12'hFFF);
    wait_done();
    pulse_tick();
    check(nframes == 2 && frames[0] === 32'h08000001, "R3 setup after reset",
          frames[0], 32'h08000001);
    check(frames[1] === exp_write(12'hFFF), "R4 full-scale sample", frames[1],
          exp_write(12'hFFF));
  endtask

  initial begin
    t_reset();
    t_first_start();
    t_second_start();
    t_start_ignored();
    t_reset_reinit();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule